// File: doc/BRIEF.md
# OFDM Burst Frame Assembler

This block builds the fixed-length transmit bursts of a baseband OFDM link for power lines. Each burst holds four symbols. The first is a synchronization pilot, a tone at half the sample rate, so its 16-sample body is made of two identical halves. The second is a fixed pilot with a sign pattern set by a parameter. The last two carry user data. Every symbol is sent as a 4-sample guard followed by its 16-sample body. The guard repeats the final four body samples. After the burst, the output stays silent until the next frame slot. A frame slot is 104 sample periods, of which 80 carry the burst.

The block produces one 14-bit two's-complement sample on each sample-enable tick. That tick comes from a divider on the faster system clock. Data symbol bodies arrive already in the time domain through a valid/ready port. Each body is collected during the symbol slot just before the one it fills, and the block then moves it to a playback buffer. The guard can therefore be sent before the body. A body that is not complete in time is replaced with zeros, and a sticky flag reports the event.

Top module: `ofdm_burst_framer`

## Requirements
- R1: While reset is asserted and right after it, dout_valid_o, dout_data_o, din_ready_o and underrun_o are all 0.
- R2: The outputs dout_data_o and dout_valid_o change only in the clock cycle after one in which sample_en_i is high.
- R3: Frame position p counts ticks modulo 104 and starts at 0 after reset. On the tick at position p, the block registers the sample for p. dout_valid_o is high for p < 80 and low for 80 ≤ p < 104.
- R4: While dout_valid_o is low, dout_data_o is zero.
- R5: Symbol s occupies positions 20s to 20s+19. Offsets 0..3 carry body samples 12..15, and offsets 4..19 carry body samples 0..15 in order.
- R6: Body sample n of symbol 0 is +5792 for even n and −5792 for odd n, so its two 8-sample halves are equal.
- R7: Body sample n of symbol 1 is −5792 when bit n of the AUX_SIGNS parameter is 1, else +5792 (default 16'h6A3C).
- R8: Symbols 2 and 3 carry the data bodies in arrival order. Body sample n is the n-th sample accepted in that body's load window.
- R9: din_ready_o is high only inside a load window and only while fewer than 16 samples of that body have been accepted. It is low on the tick cycle that closes the window. The window for data symbol j is the symbol slot just before it: positions 20..39 for symbol 2, and 40..59 for symbol 3.
- R10: If fewer than 16 samples have been accepted when a load window closes, the partial samples are dropped, the data symbol is sent as all zeros, and underrun_o goes high and stays high until reset.
- R11: din_data_i presented while din_ready_o is low has no effect on any emitted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample-rate enable tick |
| din_valid_i | input | 1 | Data body sample offered |
| din_data_i | input | 14 | Data body sample, two's complement |
| din_ready_o | output | 1 | Data body sample accepted this cycle when valid |
| dout_valid_o | output | 1 | Output sample belongs to a burst |
| dout_data_o | output | 14 | Output sample, two's complement |
| underrun_o | output | 1 | Sticky: a data body arrived incomplete |

## Verification
The bench builds the block with its default parameters: 16-sample bodies, a 4-sample guard, two pilots, two data symbols and a 104-tick frame slot. With these values both the 24-tick silent gap and the back-to-back load windows are exercised. Tick spacing varies from every clock to random gaps. At one tick per clock, a load window offers just 19 accepting cycles for 16 samples, which tests the early ready drop. A phase with a stalled source drives the underrun path and then checks that the flag stays set after the source recovers.

// File: rtl/ofdm_frm_pkg.sv
`timescale 1ns/1ps
package ofdm_frm_pkg;

   // Kind of slot the frame position currently lies in
   typedef enum logic [1:0] {
      SLOT_SYNC = 2'd0,
      SLOT_AUX  = 2'd1,
      SLOT_DATA = 2'd2,
      SLOT_GAP  = 2'd3
   } slot_kind_e;

endpackage

// File: rtl/ofdm_frm_timebase.sv
`timescale 1ns/1ps
module ofdm_frm_timebase
   import ofdm_frm_pkg::*;
#(
   parameter int SYM_LEN   = 20,
   parameter int NUM_PILOT = 2,
   parameter int NUM_SYM   = 4,
   parameter int GAP_LEN   = 24,
   localparam int SYM_W    = $clog2(NUM_SYM + 1),
   localparam int CNT_MAX  = (SYM_LEN > GAP_LEN) ? SYM_LEN : GAP_LEN,
   localparam int OFF_W    = $clog2(CNT_MAX)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   output logic [SYM_W-1:0] sym_o,
   output logic [OFF_W-1:0] off_o,
   output slot_kind_e       kind_o,
   output logic             sym_end_o
);

   logic [SYM_W-1:0] sym_q;
   logic [OFF_W-1:0] off_q;
   logic             in_sym;
   logic [SYM_W-1:0] after_last;
   logic             gap_end;

   assign in_sym    = (sym_q < SYM_W'(NUM_SYM));
   assign sym_end_o = in_sym && (off_q == OFF_W'(SYM_LEN - 1));

   // With no silent gap, the last symbol wraps straight to the next frame
   generate
      if (GAP_LEN > 0) begin : g_gap
         assign after_last = SYM_W'(NUM_SYM);
         assign gap_end    = (off_q == OFF_W'(GAP_LEN - 1));
      end else begin : g_nogap
         assign after_last = '0;
         assign gap_end    = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sym_q <= '0;
         off_q <= '0;
      end else if (tick_i) begin
         if (in_sym) begin
            if (sym_end_o) begin
               off_q <= '0;
               sym_q <= (sym_q == SYM_W'(NUM_SYM - 1)) ? after_last : sym_q + 1'b1;
            end else begin
               off_q <= off_q + 1'b1;
            end
         end else if (gap_end) begin
            off_q <= '0;
            sym_q <= '0;
         end else begin
            off_q <= off_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (!in_sym)                          kind_o = SLOT_GAP;
      else if (sym_q == '0)                 kind_o = SLOT_SYNC;
      else if (sym_q < SYM_W'(NUM_PILOT))   kind_o = SLOT_AUX;
      else                                  kind_o = SLOT_DATA;
   end

   assign sym_o = sym_q;
   assign off_o = off_q;

   AST_SYMBOL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && sym_end_o) |=> (off_q == '0)); // R5

endmodule

// File: rtl/ofdm_frm_pilot_rom.sv
`timescale 1ns/1ps
module ofdm_frm_pilot_rom #(
   parameter int                   W         = 14,
   parameter int                   BODY_LEN  = 16,
   parameter int                   AMP       = 5792,
   parameter logic [BODY_LEN-1:0]  AUX_SIGNS = '0,
   localparam int                  IDX_W     = $clog2(BODY_LEN)
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic             aux_i,
   output logic [W-1:0]     sample_o
);

   localparam logic [W-1:0] POS_LVL = W'(AMP);
   localparam logic [W-1:0] NEG_LVL = W'(-AMP);

   logic [W-1:0] sync_tab [BODY_LEN];
   logic [W-1:0] aux_tab  [BODY_LEN];

   // Tone at half the sample rate with a 45 degree phase: alternating levels
   generate
      for (genvar i = 0; i < BODY_LEN; i++) begin : g_tab
         assign sync_tab[i] = (i % 2 == 0) ? POS_LVL : NEG_LVL;
         assign aux_tab[i]  = AUX_SIGNS[i] ? NEG_LVL : POS_LVL;
      end
   endgenerate

   assign sample_o = aux_i ? aux_tab[idx_i] : sync_tab[idx_i];

endmodule

// File: rtl/ofdm_frm_data_buf.sv
`timescale 1ns/1ps
module ofdm_frm_data_buf #(
   parameter int  W        = 14,
   parameter int  BODY_LEN = 16,
   localparam int IDX_W    = $clog2(BODY_LEN),
   localparam int CNT_W    = $clog2(BODY_LEN + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             load_win_i,
   input  logic             win_end_i,
   input  logic             in_valid_i,
   input  logic [W-1:0]     in_data_i,
   output logic             ready_o,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [W-1:0]     rd_data_o,
   output logic             underrun_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [W-1:0]     load_mem [BODY_LEN];
   logic [W-1:0]     play_mem [BODY_LEN];
   logic             full;
   logic             acc;
   logic             swap;

   assign full    = (cnt_q == CNT_W'(BODY_LEN));
   assign swap    = tick_i && win_end_i;
   // The closing tick takes no sample: the swap sees a settled count
   assign ready_o = load_win_i && !full && !swap;
   assign acc     = ready_o && in_valid_i;

   always_ff @(posedge clk_i) begin
      if (acc) load_mem[cnt_q[IDX_W-1:0]] <= in_data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q      <= '0;
         underrun_o <= 1'b0;
      end else begin
         if (acc)  cnt_q <= cnt_q + 1'b1;
         if (swap) begin
            cnt_q <= '0;
            if (!full) underrun_o <= 1'b1;
         end
      end
   end

   generate
      for (genvar i = 0; i < BODY_LEN; i++) begin : g_play
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)   play_mem[i] <= '0;
            else if (swap) play_mem[i] <= full ? load_mem[i] : '0;
         end
      end
   endgenerate

   assign rd_data_o = play_mem[rd_idx_i];

   AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && cnt_q == CNT_W'(BODY_LEN - 1)) |=> !ready_o); // R9

   AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underrun_o |=> underrun_o); // R10

endmodule

// File: rtl/ofdm_burst_framer.sv
`timescale 1ns/1ps
module ofdm_burst_framer
   import ofdm_frm_pkg::*;
#(
   parameter int                  SAMPLE_W     = 14,
   parameter int                  BODY_LEN     = 16,
   parameter int                  GUARD_LEN    = 4,
   parameter int                  NUM_PILOT    = 2,
   parameter int                  NUM_DATA     = 2,
   parameter int                  FRAME_PERIOD = 104,
   parameter int                  PILOT_AMP    = 5792,
   parameter logic [BODY_LEN-1:0] AUX_SIGNS    = 16'h6A3C
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sample_en_i,
   input  logic                din_valid_i,
   input  logic [SAMPLE_W-1:0] din_data_i,
   output logic                din_ready_o,
   output logic                dout_valid_o,
   output logic [SAMPLE_W-1:0] dout_data_o,
   output logic                underrun_o
);

   localparam int SYM_LEN   = BODY_LEN + GUARD_LEN;
   localparam int NUM_SYM   = NUM_PILOT + NUM_DATA;
   localparam int FRAME_LEN = NUM_SYM * SYM_LEN;
   localparam int GAP_LEN   = FRAME_PERIOD - FRAME_LEN;
   localparam int SYM_W     = $clog2(NUM_SYM + 1);
   localparam int CNT_MAX   = (SYM_LEN > GAP_LEN) ? SYM_LEN : GAP_LEN;
   localparam int OFF_W     = $clog2(CNT_MAX);
   localparam int IDX_W     = $clog2(BODY_LEN);

   // Elaboration-time parameter checks
   generate
      if (NUM_PILOT < 1) begin : g_chk_pilot
         $error("framer: at least the sync pilot is required");
      end
      if (NUM_DATA < 1) begin : g_chk_data
         $error("framer: at least one data symbol is required");
      end
      if (GUARD_LEN < 1 || GUARD_LEN > BODY_LEN) begin : g_chk_guard
         $error("framer: guard must be 1..BODY_LEN samples");
      end
      if (GAP_LEN < 0) begin : g_chk_period
         $error("framer: frame period shorter than the burst");
      end
      if ((1 << IDX_W) != BODY_LEN) begin : g_chk_body
         $error("framer: body length must be a power of two");
      end
      if (PILOT_AMP <= 0 || PILOT_AMP >= (1 << (SAMPLE_W - 1))) begin : g_chk_amp
         $error("framer: pilot amplitude out of sample range");
      end
   endgenerate

   logic [SYM_W-1:0]    sym;
   logic [OFF_W-1:0]    off;
   slot_kind_e          kind;
   logic                sym_end;
   logic [IDX_W-1:0]    body_idx;
   logic [SAMPLE_W-1:0] pilot_smp;
   logic [SAMPLE_W-1:0] data_smp;
   logic [SAMPLE_W-1:0] next_smp;
   logic                load_win;
   logic                win_end;

   ofdm_frm_timebase #(
      .SYM_LEN   (SYM_LEN),
      .NUM_PILOT (NUM_PILOT),
      .NUM_SYM   (NUM_SYM),
      .GAP_LEN   (GAP_LEN)
   ) u_timebase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (sample_en_i),
      .sym_o     (sym),
      .off_o     (off),
      .kind_o    (kind),
      .sym_end_o (sym_end)
   );

   // Guard offsets read the body tail, later offsets read the body in order
   always_comb begin
      if (off < OFF_W'(GUARD_LEN)) body_idx = IDX_W'(off + OFF_W'(BODY_LEN - GUARD_LEN));
      else                         body_idx = IDX_W'(off - OFF_W'(GUARD_LEN));
   end

   ofdm_frm_pilot_rom #(
      .W         (SAMPLE_W),
      .BODY_LEN  (BODY_LEN),
      .AMP       (PILOT_AMP),
      .AUX_SIGNS (AUX_SIGNS)
   ) u_pilot_rom (
      .idx_i    (body_idx),
      .aux_i    (kind == SLOT_AUX),
      .sample_o (pilot_smp)
   );

   // Each data body is gathered during the slot just before it is sent
   assign load_win = (sym >= SYM_W'(NUM_PILOT - 1)) && (sym <= SYM_W'(NUM_SYM - 2));
   assign win_end  = load_win && sym_end;

   ofdm_frm_data_buf #(
      .W        (SAMPLE_W),
      .BODY_LEN (BODY_LEN)
   ) u_data_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (sample_en_i),
      .load_win_i (load_win),
      .win_end_i  (win_end),
      .in_valid_i (din_valid_i),
      .in_data_i  (din_data_i),
      .ready_o    (din_ready_o),
      .rd_idx_i   (body_idx),
      .rd_data_o  (data_smp),
      .underrun_o (underrun_o)
   );

   always_comb begin
      unique case (kind)
         SLOT_SYNC, SLOT_AUX: next_smp = pilot_smp;
         SLOT_DATA:           next_smp = data_smp;
         default:             next_smp = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dout_valid_o <= 1'b0;
         dout_data_o  <= '0;
      end else if (sample_en_i) begin
         dout_valid_o <= (kind != SLOT_GAP);
         dout_data_o  <= next_smp;
      end
   end

   AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sample_en_i |=> ($stable(dout_data_o) && $stable(dout_valid_o))); // R2

   AST_GAP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dout_valid_o |-> (dout_data_o == '0)); // R4

   AST_READY_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      din_ready_o |-> ((kind != SLOT_GAP) && (sym != SYM_W'(NUM_SYM - 1)))); // R9

endmodule

// File: tb/ofdm_burst_framer_tb.sv
`timescale 1ns/1ps
module ofdm_burst_framer_tb;

   localparam int SW   = 14;
   localparam int BL   = 16;
   localparam int G    = 4;
   localparam int NP   = 2;
   localparam int ND   = 2;
   localparam int FP   = 104;
   localparam int SL   = BL + G;
   localparam int FL   = (NP + ND) * SL;
   localparam int AMP  = 5792;
   localparam logic [BL-1:0] AUXS = 16'h6A3C;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tick;
   logic          in_valid;
   logic [SW-1:0] in_data;
   logic          ready;
   logic          out_valid;
   logic [SW-1:0] out_data;
   logic          underrun;

   always #2.5 clk = ~clk;

   ofdm_burst_framer u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .sample_en_i  (tick),
      .din_valid_i  (in_valid),
      .din_data_i   (in_data),
      .din_ready_o  (ready),
      .dout_valid_o (out_valid),
      .dout_data_o  (out_data),
      .underrun_o   (underrun)
   );

   int checks = 0;
   int errors = 0;
   int mode   = 0;
   int cyc    = 0;
   bit done   = 0;

   // ---------------- reference model ----------------
   int            m_pos;
   int            m_last_pos;
   bit            m_valid;
   bit            m_under;
   bit            m_prev_tick;
   logic [SW-1:0] m_out;
   logic [SW-1:0] q[$];
   logic [SW-1:0] play [ND][BL];
   bit            m_acc;
   int            m_j;

   function automatic int body_idx(int k);
      return (k < G) ? (BL - G + k) : (k - G);
   endfunction

   function automatic int win_index(int p);
      for (int j = 0; j < ND; j++)
         if (p >= (NP - 1 + j) * SL && p < (NP + j) * SL) return j;
      return -1;
   endfunction

   function automatic logic [SW-1:0] exp_sample(int p);
      int s, i;
      if (p >= FL) return '0;
      s = p / SL;
      i = body_idx(p % SL);
      if (s == 0) return (i % 2 == 0) ? SW'(AMP) : SW'(-AMP);
      if (s < NP) return AUXS[i] ? SW'(-AMP) : SW'(AMP);
      return play[s - NP][i];
   endfunction

   function automatic bit model_ready();
      int j;
      j = win_index(m_pos);
      if (j < 0) return 1'b0;
      if (q.size() >= BL) return 1'b0;
      if (tick && m_pos == (NP + j) * SL - 1) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_last_pos = FL; m_valid = 0; m_under = 0; m_out = '0;
         m_prev_tick = 0;
         q.delete();
         for (int j = 0; j < ND; j++)
            for (int i = 0; i < BL; i++) play[j][i] = '0;
      end else begin
         m_acc = model_ready() && in_valid;
         if (m_acc) q.push_back(in_data);
         m_prev_tick = tick;
         if (tick) begin
            m_out      = exp_sample(m_pos);
            m_valid    = (m_pos < FL);
            m_last_pos = m_pos;
            m_j        = win_index(m_pos);
            if (m_j >= 0 && m_pos == (NP + m_j) * SL - 1) begin
               if (q.size() == BL) begin
                  for (int i = 0; i < BL; i++) play[m_j][i] = q[i];
               end else begin
                  for (int i = 0; i < BL; i++) play[m_j][i] = '0;
                  m_under = 1;
               end
               q.delete();
            end
            m_pos = (m_pos + 1) % FP;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   function automatic string data_req();
      string r;
      int s, k;
      if (!m_valid) return "R4";
      s = m_last_pos / SL;
      k = m_last_pos % SL;
      if (s == 0)       r = "R6";
      else if (s < NP)  r = "R7";
      else              r = "R8 R11";
      if (k < G) r = {r, " R5"};
      if (!m_prev_tick) r = {r, " R2"};
      return r;
   endfunction

   // ---------------- stimulus and per-clock compare ----------------
   bit will_acc = 0;

   always @(negedge clk) begin
      cyc++;
      case (mode)
         1:       tick = (cyc % 2 == 0);
         2:       tick = ($urandom % 3 == 0);
         3:       tick = (cyc % 2 == 0);
         4:       tick = 1'b1;
         default: tick = 1'b0;
      endcase
      if (mode == 3) begin
         in_valid = 1'b0;
      end else if (!in_valid || will_acc) begin
         case (mode)
            1, 4:    in_valid = 1'b1;
            2:       in_valid = ($urandom % 10) < 6;
            default: in_valid = 1'b0;
         endcase
         in_data = SW'($urandom);
      end
      if (mode != 3 && ($urandom % 4 == 0) && !in_valid) in_data = SW'($urandom);
      #1;
      will_acc = in_valid && ready;
      if (rst_n && mode != 0) begin
         check(out_valid == m_valid, "R3 valid framing", int'(out_valid), int'(m_valid));
         check(out_data == m_out, data_req(), int'($signed(out_data)), int'($signed(m_out)));
         check(ready == model_ready(), "R9 ready window", int'(ready), int'(model_ready()));
         check(underrun == m_under, "R10 underrun flag", int'(underrun), int'(m_under));
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      if (!done && cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual %0d cycles expected below 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- sequence ----------------
   initial begin
      rst_n    = 1'b0;
      tick     = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      repeat (5) @(negedge clk);
      #2;
      // R1: reset state
      check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
      check(out_data == '0, "R1 reset data", int'(out_data), 0);
      check(ready == 1'b0, "R1 reset ready", int'(ready), 0);
      check(underrun == 1'b0, "R1 reset underrun", int'(underrun), 0);
      @(negedge clk);
      rst_n = 1'b1;
      mode  = 1;
      repeat (800) @(negedge clk);
      #2;
      check(underrun == 1'b0, "R10 no underrun with steady source", int'(underrun), 0);
      mode = 2;
      repeat (2000) @(negedge clk);
      mode = 3;
      repeat (500) @(negedge clk);
      #2;
      check(underrun == 1'b1, "R10 stalled source sets flag", int'(underrun), 1);
      mode = 4;
      repeat (600) @(negedge clk);
      #2;
      check(underrun == 1'b1, "R10 flag stays set after recovery", int'(underrun), 1);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule